// File: doc/BRIEF.md
# PS/2 Host-to-Device Transmitter

This block sends one command byte from a keyboard controller to an attached keyboard or mouse over the two-wire PS/2 link. A request is accepted on a single-cycle start strobe. The block then claims the bus by holding the clock line low for a programmable inhibit interval. It places the start bit on the data line and lets go of the clock. From that point the device produces the clock. On every falling edge the block presents the next bit of the frame: eight data bits with the least significant bit first, an odd parity bit, then a released stop bit. On the eleventh falling edge it samples the data line, where the device is expected to pull it low as an acknowledge.

Both lines are open-drain. The block only produces active-high pull-down enables and reads the line levels back through its own synchronisers. A watchdog measured in system-clock cycles covers the whole transfer, from acceptance to acknowledge. When it expires, because the device never clocked or clocked too slowly, the block releases both lines. It then finishes with the timeout flag set and the result code 0xFE. Completion is signalled by a one-cycle done pulse. The flags and code stay valid until the next accepted request.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset, both pull-down enables are inactive, busy_o, done_o, nack_o and tmo_o are 0, and code_o is 0x00.
- R2: After a start is accepted, the clock pull-down enable is asserted for exactly INHIBIT_CYC cycles with the data line released. In the first cycle that the clock is released, the data pull-down is asserted (start bit = 0).
- R3: The data line changes only after a falling edge of the synchronised device clock. The bit presented after falling edge k (k = 1..8) is bit k-1 of the byte, so the least significant bit goes first.
- R4: After the ninth falling edge the line carries odd parity, so the line level equals the inverted XOR of the eight data bits. After the tenth falling edge the data line is released (stop bit = 1).
- R5: On the eleventh falling edge the data line is sampled. Low means acknowledge (nack_o = 0) and high means a missing acknowledge (nack_o = 1). done_o then pulses high for exactly one cycle and busy_o falls.
- R6: If the transfer has not completed TIMEOUT_CYC cycles after acceptance, both lines are released, done_o pulses, tmo_o = 1 and code_o = 0xFE. Otherwise code_o = 0x00.
- R7: A device that never produces a clock after the bus request ends in the timeout of R6, with busy_o held for TIMEOUT_CYC cycles plus the one done cycle.
- R8: A start strobe that arrives while busy_o is high is ignored, and the byte in flight is sent unchanged.
- R9: A device clock that toggles while the block is idle leaves both pull-down enables inactive and busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send byte_i |
| byte_i | input | 8 | Byte to send, captured when start_i is accepted |
| kbd_clk_i | input | 1 | Level of the PS/2 clock line |
| kbd_dat_i | input | 1 | Level of the PS/2 data line |
| kbd_clk_oe_o | output | 1 | Pull clock line low when 1 |
| kbd_dat_oe_o | output | 1 | Pull data line low when 1 |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| nack_o | output | 1 | Last transfer saw no acknowledge |
| tmo_o | output | 1 | Last transfer timed out |
| code_o | output | 8 | 0xFE after a timeout, 0x00 otherwise |

## Verification
The bench acts as the device. It samples the data line on its own rising clock edges and compares the captured frame with one built from the byte, so a design that sends the most significant bit first or uses even parity shows a wrong frame. An off-by-one in the inhibit counter appears as a clock-low period of the wrong length, and a start bit placed late appears as a released data line when the clock is let go. Two timeout cases are tested: a device that never clocks, where the busy time is measured against the limit, and a device that clocks too slowly. A design that kept the lines driven or reported the wrong code after an abort fails here. A second start during a transfer, and idle clock toggling, catch a design that reloads its shifter or reacts to stray edges.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER, ST_FIN} tx_state_e;
  localparam logic [7:0] TMO_CODE   = 8'hFE;
  localparam logic [7:0] OK_CODE    = 8'h00;
  localparam int unsigned SHIFT_BITS = 10;  // data, parity, stop
endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ps2tx_edge.sv
module ps2tx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/ps2tx_wdog.sv
module ps2tx_wdog #(
  parameter int unsigned LIMIT = 180000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  AST_WDOG_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/ps2tx_ctrl.sv
module ps2tx_ctrl
  import ps2tx_pkg::*;
#(
  parameter int unsigned INHIBIT_CYC = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       fall_i,
  input  logic       dat_s_i,
  input  logic       expire_i,
  output logic       clk_oe_o,
  output logic       dat_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       tmo_o
);
  localparam int unsigned RW = $clog2(INHIBIT_CYC + 1);
  localparam logic [RW-1:0] REQ_LAST = RW'(INHIBIT_CYC - 1);
  localparam logic [3:0] ACK_IDX = 4'(SHIFT_BITS);

  tx_state_e             state_q;
  logic [RW-1:0]         req_cnt_q;
  logic [SHIFT_BITS-1:0] shreg_q;
  logic [3:0]            bit_q;
  logic                  tx_bit_q;
  logic                  nack_q, tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_cnt_q <= '0;
      shreg_q   <= '1;
      bit_q     <= '0;
      tx_bit_q  <= 1'b1;
      nack_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tx_bit_q <= 1'b1;
          if (start_i) begin
            shreg_q   <= {1'b1, ~^byte_i, byte_i};
            req_cnt_q <= '0;
            nack_q    <= 1'b0;
            tmo_q     <= 1'b0;
            state_q   <= ST_REQ;
          end
        end
        ST_REQ: begin
          req_cnt_q <= req_cnt_q + 1'b1;
          if (expire_i) begin
            tmo_q   <= 1'b1;
            state_q <= ST_FIN;
          end else if (req_cnt_q == REQ_LAST) begin
            tx_bit_q <= 1'b0;  // start bit
            bit_q    <= '0;
            state_q  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (expire_i) begin
            tmo_q    <= 1'b1;
            tx_bit_q <= 1'b1;
            state_q  <= ST_FIN;
          end else if (fall_i) begin
            if (bit_q == ACK_IDX) begin
              nack_q  <= dat_s_i;
              state_q <= ST_FIN;
            end else begin
              tx_bit_q <= shreg_q[0];
              shreg_q  <= {1'b1, shreg_q[SHIFT_BITS-1:1]};
              bit_q    <= bit_q + 1'b1;
            end
          end
        end
        ST_FIN: begin
          tx_bit_q <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clk_oe_o = (state_q == ST_REQ);
  assign dat_oe_o = (state_q == ST_XFER) && !tx_bit_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign nack_o   = nack_q;
  assign tmo_o    = tmo_q;

  AST_REQ_DATA_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o |-> !dat_oe_o); // R2
  AST_START_BIT_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_oe_o) && state_q == ST_XFER) |-> dat_oe_o); // R2
  AST_BIT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && $past(state_q == ST_XFER) && !$past(fall_i)) |-> $stable(tx_bit_q)); // R3
  AST_SHREG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && $past(state_q == ST_REQ)) |-> $stable(shreg_q)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R5
  AST_WDOG_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && busy_o && !done_o) |=> (done_o && tmo_o)); // R6
  AST_IDLE_LINES_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!clk_oe_o && !dat_oe_o)); // R9
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2tx_pkg::*;
#(
  parameter int unsigned INHIBIT_CYC = 1200,
  parameter int unsigned TIMEOUT_CYC = 180000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  output logic       kbd_clk_oe_o,
  output logic       kbd_dat_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       tmo_o,
  output logic [7:0] code_o
);
  logic [1:0] line_s;
  logic       fall;
  logic       expire;
  logic       busy;

  ps2tx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({kbd_clk_i, kbd_dat_i}),
    .q_o   (line_s)
  );

  ps2tx_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (line_s[1]),
    .fall_o(fall)
  );

  ps2tx_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy && !done_o),
    .expire_o(expire)
  );

  ps2tx_ctrl #(.INHIBIT_CYC(INHIBIT_CYC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .byte_i  (byte_i),
    .fall_i  (fall),
    .dat_s_i (line_s[0]),
    .expire_i(expire),
    .clk_oe_o(kbd_clk_oe_o),
    .dat_oe_o(kbd_dat_oe_o),
    .busy_o  (busy),
    .done_o  (done_o),
    .nack_o  (nack_o),
    .tmo_o   (tmo_o)
  );

  assign busy_o = busy;
  assign code_o = tmo_o ? TMO_CODE : OK_CODE;

  AST_TMO_LINES_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !busy_o) |-> (!kbd_clk_oe_o && !kbd_dat_oe_o)); // R6
  AST_TMO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> (code_o == 8'hFE)); // R6
endmodule

// File: tb/tb_ps2_host_tx.sv
module tb_ps2_host_tx;
  localparam int unsigned INHIBIT = 20;
  localparam int unsigned TMO     = 3000;
  localparam int unsigned HALF    = 40;

  // {byte, device acknowledges}
  localparam logic [8:0] VEC [8] = '{
    {8'h00, 1'b1}, {8'hFF, 1'b1}, {8'hA5, 1'b1}, {8'h5A, 1'b0},
    {8'h01, 1'b1}, {8'h80, 1'b0}, {8'hF4, 1'b1}, {8'hED, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] byte_in = '0;
  logic dev_clk = 1'b1;
  logic dev_dat_low = 1'b0;
  logic clk_oe, dat_oe, busy, done, nack, tmo;
  logic [7:0] code;
  wire clk_line = ~clk_oe & dev_clk;
  wire dat_line = ~dat_oe & ~dev_dat_low;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ps2_host_tx #(.INHIBIT_CYC(INHIBIT), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(byte_in),
    .kbd_clk_i(clk_line), .kbd_dat_i(dat_line),
    .kbd_clk_oe_o(clk_oe), .kbd_dat_oe_o(dat_oe),
    .busy_o(busy), .done_o(done), .nack_o(nack), .tmo_o(tmo), .code_o(code)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] b);
    return {1'b1, ~^b, b};
  endfunction

  task automatic do_start(input logic [7:0] b);
    @(negedge clk);
    byte_in = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // device side: checks bus request, clocks 11 edges, samples on rising edges
  task automatic dev_xfer(input int half, input bit give_ack, output logic [9:0] got);
    int len = 0;
    int guard = 0;
    bit dat_ok = 1'b1;
    got = '0;
    while (!clk_oe && guard < 100) begin @(negedge clk); guard++; end
    while (clk_oe && len < 10 * INHIBIT) begin
      if (dat_oe) dat_ok = 1'b0;
      len++;
      @(negedge clk);
    end
    chk("R2 inhibit length", len, INHIBIT);
    chk("R2 data released in request", dat_ok, 1'b1);
    chk("R2 start bit at release", dat_oe, 1'b1);
    repeat (half) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      dev_clk = 1'b0;
      repeat (half) @(negedge clk);
      dev_clk = 1'b1;
      got[i] = dat_line;
      repeat (half) @(negedge clk);
    end
    dev_dat_low = give_ack;
    dev_clk = 1'b0;
    repeat (half) @(negedge clk);
    dev_clk = 1'b1;
    repeat (half) @(negedge clk);
    dev_dat_low = 1'b0;
  endtask

  task automatic wait_idle(input int limit, output int cyc);
    cyc = 0;
    while (busy && cyc < limit) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] got;
    logic [9:0] exp_f;
    int cyc;
    int d0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 clk_oe", clk_oe, 0);
    chk("R1 dat_oe", dat_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 flags", {nack, tmo}, 0);
    chk("R1 code", code, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      d0 = done_cnt;
      do_start(VEC[v][8:1]);
      dev_xfer(HALF, VEC[v][0], got);
      wait_idle(500, cyc);
      exp_f = frame_of(VEC[v][8:1]);
      chk("R3 data bits lsb first", got[7:0], exp_f[7:0]);
      chk("R4 odd parity", got[8], exp_f[8]);
      chk("R4 stop bit", got[9], 1'b1);
      chk("R5 ack result", nack, !VEC[v][0]);
      chk("R5 single done pulse", done_cnt - d0, 1);
      chk("R6 no timeout", {tmo, code}, {1'b0, 8'h00});
      repeat (10) @(negedge clk);
    end

    // R7: device never clocks
    d0 = done_cnt;
    do_start(8'hF2);
    wait_idle(TMO + 100, cyc);
    chk("R7 busy duration", (cyc >= TMO - 2 && cyc <= TMO + 2), 1);
    chk("R7 timeout flag", tmo, 1'b1);
    chk("R6 timeout code", code, 8'hFE);
    chk("R6 lines released", {clk_oe, dat_oe}, 2'b00);
    chk("R6 done once", done_cnt - d0, 1);

    // R6: device clocks too slowly, abort mid-frame; later edges hit idle block (R9)
    do_start(8'h3C);
    dev_xfer(200, 1'b1, got);
    chk("R6 slow device timeout", {tmo, code}, {1'b1, 8'hFE});
    chk("R9 idle after abort", {busy, clk_oe, dat_oe}, 3'b000);

    // success after timeout clears flags
    do_start(8'h11);
    dev_xfer(HALF, 1'b1, got);
    wait_idle(500, cyc);
    chk("R6 flags cleared on new start", {tmo, nack, code}, 10'h000);

    // R8: second start while busy is ignored
    do_start(8'h3C);
    fork
      dev_xfer(HALF, 1'b1, got);
      begin
        repeat (5) @(negedge clk);
        byte_in = 8'hC3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    wait_idle(500, cyc);
    chk("R8 byte unchanged", got, frame_of(8'h3C));
    repeat (10) @(negedge clk);
    chk("R8 no extra transfer", busy, 1'b0);

    // R9: idle clock toggling
    for (int i = 0; i < 12; i++) begin
      dev_clk = ~dev_clk;
      repeat (6) @(negedge clk);
      if (clk_oe || dat_oe || busy) begin
        chk("R9 idle edge ignored", {busy, clk_oe, dat_oe}, 3'b000);
      end
    end
    dev_clk = 1'b1;
    chk("R9 idle lines free", {busy, clk_oe, dat_oe}, 3'b000);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule